// File: doc/BRIEF.md
# Modem Control and Status Unit

This block handles the modem handshake lines of a serial port. Four active-low status inputs come in from the modem: clear-to-send, data-set-ready, ring indicator and carrier detect. Each passes through a synchroniser. The block then shows them in an eight-bit status word. The upper half of that word holds the asserted (true-level) state of each line. The lower half holds sticky change flags, and any status read clears them. A single control register drives two active-low outputs, terminal-ready and request-to-send. The same register selects loop mode, the modem-status interrupt enable and a hardware flow-control mode.

In flow-control mode the block gates the transmitter. A new character may start only while clear-to-send is asserted. A character already on the line is never aborted, because the block only withholds permission to start the next one. When the transmitter reports the end of a final stop bit and its holding register is empty, the block clears the request-to-send control bit by itself. That releases the request-to-send output. The serial shifter sits outside this block and connects through three handshake signals.

Top module: `modem_ctl_unit`

## Requirements
- R1: Status bits 7, 6, 5 and 4 read as 1 while carrier-detect, ring, data-set-ready and clear-to-send (respectively) are held low. They read as 0 while the line is high.
- R2: Status bit 0 sets on any change of clear-to-send, bit 1 on any change of data-set-ready, and bit 3 on any change of carrier-detect. Each bit stays set until the next status read.
- R3: Status bit 2 sets only when the ring input goes from low to high (ring level bit falling 1 to 0). A high-to-low ring transition leaves it clear.
- R4: A status read (statRdEn high for one cycle) clears bits 0 to 3. A change that is recorded on the same clock edge as the read survives the read.
- R5: msIrq is high exactly when control bit 3 (interrupt enable) is 1 and at least one of status bits 0 to 3 is set. A read with no new change drops it on the next cycle.
- R6: Control bit 0 = 1 drives dtrOutN low and bit 1 = 1 drives rtsOutN low, one cycle after the write. Reset clears the control register and drives both outputs high.
- R7: With control bit 2 (loop) set, dtrOutN stays high whatever control bit 0 holds.
- R8: With control bit 4 (flow control) set, txStartOk follows the synchronised clear-to-send (1 when asserted low). With bit 4 clear, txStartOk is always 1.
- R9: In flow-control mode, a txLastStop pulse while txHoldFull is 0 clears control bit 1 and so releases rtsOutN to high. The same pulse with txHoldFull high has no effect, and so does any pulse outside flow-control mode.
- R10: A status input change shows in the level bit after two clock edges, and in its change bit one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control register |
| ctlWrData | input | 5 | Control write data: 0 terminal-ready, 1 request-to-send, 2 loop, 3 interrupt enable, 4 flow control |
| ctlRdData | output | 5 | Current control register value |
| statRdEn | input | 1 | Status read strobe; clears the change bits |
| statRdData | output | 8 | Status word: 7..4 levels of carrier, ring, data-set-ready, clear-to-send; 3..0 change flags |
| ctsInN | input | 1 | Clear-to-send, active low, asynchronous |
| dsrInN | input | 1 | Data-set-ready, active low, asynchronous |
| riInN | input | 1 | Ring indicator, active low, asynchronous |
| dcdInN | input | 1 | Carrier detect, active low, asynchronous |
| dtrOutN | output | 1 | Terminal-ready, active low |
| rtsOutN | output | 1 | Request-to-send, active low |
| msIrq | output | 1 | Modem-status interrupt |
| txHoldFull | input | 1 | Transmit holding register holds a character |
| txLastStop | input | 1 | One-cycle pulse at the end of a character's final stop bit |
| txStartOk | output | 1 | Transmitter may start a new character |

## Verification
A faulty synchroniser or edge register shows at the status word within three clock edges of an input change. It appears either as a level bit arriving on the wrong edge or as a change flag set in the wrong direction, which the ring flag in particular makes visible. A faulty clear path is visible on the first read. It shows either as flags that survive a read or as a flag lost when a change lands on the read edge, and the interrupt output reports the same error in the following cycle. Errors in the control register or the flow-control logic show at dtrOutN, rtsOutN and txStartOk one cycle after the write or stop-bit pulse that should have changed them.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int CTL_W      = 5;
  localparam int CTL_DTR    = 0;
  localparam int CTL_RTS    = 1;
  localparam int CTL_LOOP   = 2;
  localparam int CTL_IEN    = 3;
  localparam int CTL_FLOW   = 4;
  localparam int LINES      = 4;   // index 0 cts, 1 dsr, 2 ring, 3 carrier
  localparam int LINE_CTS   = 0;
  localparam int LINE_DSR   = 1;
  localparam int LINE_RING  = 2;
  localparam int LINE_DCD   = 3;
  localparam int STAT_W     = 2 * LINES;

  typedef struct packed {
    logic clrDelta;    // status read: clear change flags
    logic ctlLoad;     // load control register from write data
    logic rtsAutoClr;  // hardware release of request-to-send
  } ctlStrobeT;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= {WIDTH{RESET_VAL}};
        else       stage[g] <= asyncIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= {WIDTH{RESET_VAL}};
        else       stage[g] <= stage[g-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/modem_datapath.sv
module modem_datapath
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeT            strb,
  input  logic [CTL_W-1:0]     ctlWrData,
  input  logic [LINES-1:0]     lineInN,
  output logic [STAT_W-1:0]    statusWord,
  output logic [CTL_W-1:0]     ctlReg,
  output logic                 anyEvt,
  output logic                 ctsActive
);
  logic [LINES-1:0] lineSync;
  logic [LINES-1:0] holdPrev;
  logic [LINES-1:0] evt;
  logic [LINES-1:0] delta;
  logic             clrDelta;

  assign clrDelta = strb.clrDelta;

  modem_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (lineInN),
    .syncOut (lineSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) holdPrev <= '1;
    else       holdPrev <= lineSync;

  // change detection: any edge on three lines, trailing edge of ring only
  for (genvar i = 0; i < LINES; i++) begin : g_evt
    if (i == LINE_RING) begin : g_ring
      assign evt[i] = lineSync[i] & ~holdPrev[i];
    end else begin : g_any
      assign evt[i] = lineSync[i] ^ holdPrev[i];
    end
  end

  assign anyEvt = |evt;

  // a new change wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) delta <= '0;
    else       delta <= (delta & ~{LINES{clrDelta}}) | evt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              ctlReg <= '0;
    else if (strb.ctlLoad)  ctlReg <= ctlWrData;
    else if (strb.rtsAutoClr) ctlReg[CTL_RTS] <= 1'b0;

  assign statusWord = {~lineSync, delta};
  assign ctsActive  = ~lineSync[LINE_CTS];

  // R2
  // delta_hold_chk: flags only drop on a read
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrDelta) |-> ((delta & $past(delta)) == $past(delta)));

  // R3
  // ring_trail_chk: ring flag only rises after the synchronised line went high
  ring_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delta[LINE_RING]) |-> $past(lineSync[LINE_RING]));

  // R4
  // clear_chk: a read with no new change leaves the flags clear
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrDelta && !anyEvt) |=> (delta == '0));
endmodule

// File: rtl/modem_control.sv
module modem_control
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic             statRdEn,
  input  logic             txHoldFull,
  input  logic             txLastStop,
  input  logic [CTL_W-1:0] ctlReg,
  input  logic [LINES-1:0] delta,
  input  logic             anyEvt,
  input  logic             ctsActive,
  output ctlStrobeT        strb,
  output logic             dtrOutN,
  output logic             rtsOutN,
  output logic             msIrq,
  output logic             txStartOk
);
  logic flowOn;

  assign flowOn = ctlReg[CTL_FLOW];

  always_comb begin
    strb            = '0;
    strb.clrDelta   = statRdEn;
    strb.ctlLoad    = ctlWrEn;
    strb.rtsAutoClr = flowOn & txLastStop & ~txHoldFull;
  end

  assign dtrOutN   = ~(ctlReg[CTL_DTR] & ~ctlReg[CTL_LOOP]);
  assign rtsOutN   = ~ctlReg[CTL_RTS];
  assign msIrq     = ctlReg[CTL_IEN] & (|delta);
  assign txStartOk = ~flowOn | ctsActive;

  // R5
  // irq_drop_chk: a read with nothing new pending removes the interrupt
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDelta && !anyEvt && !ctlWrEn) |=> !msIrq);

  // R7
  // loop_dtr_chk: loop mode keeps terminal-ready inactive
  loop_dtr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlReg[CTL_LOOP] |-> dtrOutN);

  // R9
  // rts_release_chk: end of last character in flow mode releases request-to-send
  rts_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowOn && txLastStop && !txHoldFull && !ctlWrEn) |=> rtsOutN);

  // R8
  // start_gate_chk: no start permission in flow mode while clear-to-send is inactive
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowOn && !ctsActive) |-> !txStartOk);
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [CTL_W-1:0]  ctlWrData,
  output logic [CTL_W-1:0]  ctlRdData,
  input  logic              statRdEn,
  output logic [STAT_W-1:0] statRdData,
  input  logic              ctsInN,
  input  logic              dsrInN,
  input  logic              riInN,
  input  logic              dcdInN,
  output logic              dtrOutN,
  output logic              rtsOutN,
  output logic              msIrq,
  input  logic              txHoldFull,
  input  logic              txLastStop,
  output logic              txStartOk
);
  ctlStrobeT        strb;
  logic [CTL_W-1:0] ctlReg;
  logic             anyEvt;
  logic             ctsActive;

  modem_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ctlWrData  (ctlWrData),
    .lineInN    ({dcdInN, riInN, dsrInN, ctsInN}),
    .statusWord (statRdData),
    .ctlReg     (ctlReg),
    .anyEvt     (anyEvt),
    .ctsActive  (ctsActive)
  );

  modem_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .ctlWrEn    (ctlWrEn),
    .statRdEn   (statRdEn),
    .txHoldFull (txHoldFull),
    .txLastStop (txLastStop),
    .ctlReg     (ctlReg),
    .delta      (statRdData[LINES-1:0]),
    .anyEvt     (anyEvt),
    .ctsActive  (ctsActive),
    .strb       (strb),
    .dtrOutN    (dtrOutN),
    .rtsOutN    (rtsOutN),
    .msIrq      (msIrq),
    .txStartOk  (txStartOk)
  );

  assign ctlRdData = ctlReg;
endmodule

// File: tb/tb_modem_ctl_unit.sv
module tb_modem_ctl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {dcdN, riN, dsrN, ctsN, expected status}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b1110, 8'h11}, {4'b1100, 8'h32}, {4'b1000, 8'h70}, {4'b1100, 8'h34},
    {4'b0100, 8'hB8}, {4'b1111, 8'h0B}, {4'b0000, 8'hFB}, {4'b1111, 8'h0F}
  };

  logic clk = 0, rstN = 0;
  logic ctlWrEn = 0, statRdEn = 0;
  logic [4:0] ctlWrData = '0;
  logic [4:0] ctlRdData;
  logic [7:0] statRdData;
  logic ctsInN = 1, dsrInN = 1, riInN = 1, dcdInN = 1;
  logic dtrOutN, rtsOutN, msIrq, txStartOk;
  logic txHoldFull = 0, txLastStop = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctl_unit dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .statRdEn(statRdEn), .statRdData(statRdData),
    .ctsInN(ctsInN), .dsrInN(dsrInN), .riInN(riInN), .dcdInN(dcdInN),
    .dtrOutN(dtrOutN), .rtsOutN(rtsOutN), .msIrq(msIrq),
    .txHoldFull(txHoldFull), .txLastStop(txLastStop), .txStartOk(txStartOk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [4:0] v);
    @(negedge clk); ctlWrEn = 1; ctlWrData = v;
    @(posedge clk); @(negedge clk); ctlWrEn = 0;
  endtask

  task automatic statRead();
    @(negedge clk); statRdEn = 1;
    @(posedge clk); @(negedge clk); statRdEn = 0;
  endtask

  task automatic setLines(input logic [3:0] v);
    @(negedge clk); {dcdInN, riInN, dsrInN, ctsInN} = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stopPulse(input logic hold);
    @(negedge clk); txHoldFull = hold; txLastStop = 1;
    @(posedge clk); @(negedge clk); txLastStop = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state, R6
    chk("R6 reset status", statRdData, 8'h00);
    chk("R6 reset ctl", ctlRdData, 5'h00);
    chk("R6 reset dtr", dtrOutN, 1'b1);
    chk("R6 reset rts", rtsOutN, 1'b1);
    chk("R5 reset irq", msIrq, 1'b0);
    chk("R8 reset start", txStartOk, 1'b1);
    rstN = 1;
    settle();

    // table walk: R1 R2 R3 R4 R5
    ctlWrite(5'h08);
    for (int i = 0; i < NVEC; i++) begin
      setLines(VEC[i][11:8]);
      settle();
      chk("R1/R2/R3 status", statRdData, VEC[i][7:0]);
      chk("R5 irq", msIrq, |VEC[i][3:0]);
      statRead();
      chk("R4 cleared", statRdData[3:0], 4'h0);
      chk("R5 irq after read", msIrq, 1'b0);
    end

    // R10 latency
    setLines(4'b1110);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 level after 2", statRdData[4], 1'b1);
    chk("R10 flag not yet", statRdData[0], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R10 flag after 3", statRdData[0], 1'b1);
    statRead();

    // R4 change landing on the read edge is kept
    setLines(4'b1111);
    settle();
    chk("R4 setup", statRdData[3:0], 4'h1);
    setLines(4'b1101);
    @(posedge clk); @(posedge clk); @(negedge clk);
    statRdEn = 1;
    @(posedge clk); @(negedge clk); statRdEn = 0;
    chk("R4 same-edge change kept", statRdData[3:0], 4'h2);
    chk("R5 irq held", msIrq, 1'b1);
    statRead();
    chk("R5 irq dropped", msIrq, 1'b0);

    // R5 disabled interrupt
    ctlWrite(5'h00);
    setLines(4'b1111);
    settle();
    chk("R2 flag with irq off", statRdData[1], 1'b1);
    chk("R5 irq off", msIrq, 1'b0);
    ctlWrite(5'h08);
    chk("R5 irq on enable", msIrq, 1'b1);
    statRead();

    // R6 / R7
    ctlWrite(5'h03);
    chk("R6 dtr active", dtrOutN, 1'b0);
    chk("R6 rts active", rtsOutN, 1'b0);
    ctlWrite(5'h07);
    chk("R7 loop dtr", dtrOutN, 1'b1);
    chk("R7 loop rts", rtsOutN, 1'b0);

    // R8 flow gating
    ctlWrite(5'h12);
    settle();
    chk("R8 cts inactive blocks", txStartOk, 1'b0);
    setLines(4'b1110);
    settle();
    chk("R8 cts active allows", txStartOk, 1'b1);

    // R9 auto release
    stopPulse(1'b1);
    chk("R9 hold full keeps rts", rtsOutN, 1'b0);
    stopPulse(1'b0);
    chk("R9 rts released", rtsOutN, 1'b1);
    chk("R9 ctl bit cleared", ctlRdData, 5'h10);

    // outside flow mode
    ctlWrite(5'h02);
    setLines(4'b1111);
    settle();
    chk("R8 no flow start ok", txStartOk, 1'b1);
    stopPulse(1'b0);
    chk("R9 no flow keeps rts", rtsOutN, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule